// File: doc/BRIEF.md
# Address-Keyed Memory Encryption Interface

This block joins a data path that carries every value as two XOR shares to a data memory that holds one word per address. Neither the plain value nor the two shares ever reach memory. On a store the block folds both shares into a single ciphertext word, using a keystream that is derived from a session seed and the access address. On a load it strips the same keystream from the returned word and splits the result into two new shares, using a fresh random word.

Several session seeds are held side by side. A control-register select picks the seed that accesses use. Software can rewrite any seed through an indexed control-register write port. The keystream is recomputed from the live seed and the address on every access. A load captures its keystream when it is issued, so a seed change never alters a load that is already in flight. The memory side is a plain request port with a one-word read return, and the random word comes from outside.

Top module: `mcrypt_if`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid` is low. Reset clears every seed to zero and clears the key select to 0.
- R2: An access is passed to memory in the same cycle. `mem_req` follows `req_valid`, `mem_we` follows `req_write`, and `mem_addr` follows `req_addr`.
- R3: The word written on a store depends on the two shares only through their XOR. Any split of a value gives the same ciphertext.
- R4: For a fixed seed, key select and address, the ciphertext XOR the plain value is a constant. Two stores of v1 and v2 give ciphertexts whose XOR is v1 XOR v2.
- R5: One cycle after `mem_rvalid` is high, `rsp_valid` is high, and `rsp_share0 XOR rsp_share1` equals the value that was stored at that address under the same seed.
- R6: `rsp_share1` equals the `rnd_word` value that was present in the cycle in which `mem_rvalid` was high.
- R7: With nonzero seeds, the word held in memory differs from the plain value that was stored.
- R8: `csr_sel_we` with `csr_sel_wdata` = i makes seed i the session key. The same value stored at the same address under key 0 and under key 1 (different seeds) gives different memory words.
- R9: `csr_seed_we` with index i replaces only seed i. Data stored under another seed still reads back correctly. Data stored under seed i before the rewrite no longer recombines to its value.
- R10: A seed write in the same cycle as a load issue does not change that load's result. Loads issued later use the new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_seed_we | input | 1 | Seed write strobe |
| csr_seed_idx | input | SEL_W | Index of the seed to write |
| csr_seed_wdata | input | DATA_W | New seed value |
| csr_sel_we | input | 1 | Key select write strobe |
| csr_sel_wdata | input | SEL_W | New key select |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_share0 | input | DATA_W | Store data, share 0 |
| req_share1 | input | DATA_W | Store data, share 1 |
| rnd_word | input | DATA_W | Fresh random word for load re-masking |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Ciphertext to memory |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Ciphertext from memory |
| rsp_valid | output | 1 | Load response valid |
| rsp_share0 | output | DATA_W | Load result, share 0 |
| rsp_share1 | output | DATA_W | Load result, share 1 |

## Verification
The assertions assume that each `mem_rvalid` answers exactly one earlier load and that at most one load is outstanding. They also assume that `rnd_word` is held for the whole cycle in which read data returns. The bench memory model answers every load one cycle after the request. The bench waits for each response before it issues the next access and drives `rnd_word` only in the return cycle. Seeds are set to nonzero values before any data is stored, so the ciphertext-versus-plaintext checks are meaningful.

// File: rtl/mcrypt_pkg.sv
package mcrypt_pkg;
  // Rotation amounts and additive constant of the keystream round
  localparam int unsigned MIX_ROT_A = 7;
  localparam int unsigned MIX_ROT_B = 11;
  localparam int unsigned MIX_ROT_C = 17;
  localparam logic [63:0] MIX_ADD   = 64'h9E37_79B9_7F4A_7C15;
  localparam int unsigned MAX_DATA_W = 64;
endpackage

// File: rtl/mcrypt_seed_bank.sv
module mcrypt_seed_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_KEYS = 2,
  localparam int unsigned SEL_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_we,
  input  logic [SEL_W-1:0]  seed_idx,
  input  logic [DATA_W-1:0] seed_wdata,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_wdata,
  output logic [DATA_W-1:0] seed_active
);
  logic [NUM_KEYS*DATA_W-1:0] seeds_flat;
  logic [SEL_W-1:0]           sel_q;
  logic                       sel_en;

  // Select register: writes of an out-of-range index are dropped
  always_comb begin
    sel_en = sel_we && (int'(sel_wdata) < NUM_KEYS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_wdata;
    end
  end

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_seed
    logic [DATA_W-1:0] seed_q;
    logic              seed_en;

    always_comb begin
      seed_en = seed_we && (int'(seed_idx) == g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seed_q <= '0;
      end else if (seed_en) begin
        seed_q <= seed_wdata;
      end
    end

    assign seeds_flat[g*DATA_W +: DATA_W] = seed_q;
  end

  assign seed_active = seeds_flat[int'(sel_q)*DATA_W +: DATA_W];
endmodule

// File: rtl/mcrypt_keymix.sv
module mcrypt_keymix
  import mcrypt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic [DATA_W-1:0] seed,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] key
);
  localparam int unsigned RA = MIX_ROT_A % DATA_W;
  localparam int unsigned RB = MIX_ROT_B % DATA_W;
  localparam int unsigned RC = MIX_ROT_C % DATA_W;
  localparam logic [DATA_W-1:0] ADD_C = MIX_ADD[DATA_W-1:0];

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v, input int unsigned r);
    logic [2*DATA_W-1:0] d;
    d = {v, v} << r;
    return d[2*DATA_W-1:DATA_W];
  endfunction

  logic [DATA_W-1:0] v_in, a_st, b_st;

  // One fixed round: rotate-xor, rotate-add with constant, rotate-xor
  always_comb begin
    v_in = seed ^ DATA_W'(addr);
    a_st = v_in ^ rotl(v_in, RA);
    b_st = a_st + rotl(a_st, RB) + ADD_C;
    key  = b_st ^ rotl(b_st, RC);
  end
endmodule

// File: rtl/mcrypt_load_path.sv
module mcrypt_load_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [DATA_W-1:0] key_now,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] rnd_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_share0,
  output logic [DATA_W-1:0] rsp_share1
);
  logic [DATA_W-1:0] key_hold_q;
  logic [DATA_W-1:0] sh0_d, sh1_d;
  logic              rsp_valid_d;

  // Key captured at issue so later seed writes cannot reach this load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_hold_q <= '0;
    end else if (issue) begin
      key_hold_q <= key_now;
    end
  end

  // Remask first, then strip the keystream: plain value never sits alone
  always_comb begin
    rsp_valid_d = mem_rvalid;
    sh0_d       = (mem_rdata ^ rnd_word) ^ key_hold_q;
    sh1_d       = rnd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_share0 <= '0;
      rsp_share1 <= '0;
    end else if (mem_rvalid) begin
      rsp_share0 <= sh0_d;
      rsp_share1 <= sh1_d;
    end
  end
endmodule

// File: rtl/mcrypt_if.sv
module mcrypt_if
  import mcrypt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_KEYS = 2,
  localparam int unsigned SEL_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_seed_we,
  input  logic [SEL_W-1:0]  csr_seed_idx,
  input  logic [DATA_W-1:0] csr_seed_wdata,
  input  logic              csr_sel_we,
  input  logic [SEL_W-1:0]  csr_sel_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_share0,
  input  logic [DATA_W-1:0] req_share1,
  input  logic [DATA_W-1:0] rnd_word,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_share0,
  output logic [DATA_W-1:0] rsp_share1
);
  initial begin
    if (DATA_W > MAX_DATA_W || ADDR_W > DATA_W || NUM_KEYS < 2)
      $error("mcrypt_if: unsupported parameter set");
  end

  logic [DATA_W-1:0] seed_active;
  logic [DATA_W-1:0] key_now;
  logic              load_issue;

  mcrypt_seed_bank #(.DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS)) u_seeds (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_we    (csr_seed_we),
    .seed_idx   (csr_seed_idx),
    .seed_wdata (csr_seed_wdata),
    .sel_we     (csr_sel_we),
    .sel_wdata  (csr_sel_wdata),
    .seed_active(seed_active)
  );

  mcrypt_keymix #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mix (
    .seed(seed_active),
    .addr(req_addr),
    .key (key_now)
  );

  always_comb begin
    load_issue = req_valid && !req_write;
    mem_req    = req_valid;
    mem_we     = req_write;
    mem_addr   = req_addr;
    // share 0 is keyed before share 1 joins in
    mem_wdata  = (req_share0 ^ key_now) ^ req_share1;
  end

  mcrypt_load_path #(.DATA_W(DATA_W)) u_load (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (load_issue),
    .key_now   (key_now),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .rnd_word  (rnd_word),
    .rsp_valid (rsp_valid),
    .rsp_share0(rsp_share0),
    .rsp_share1(rsp_share1)
  );
endmodule

// File: rtl/mcrypt_if_chk.sv
module mcrypt_if_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rvalid,
  input logic [DATA_W-1:0] rnd_word,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_share1
);
  // R1
  rsp_idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !rsp_valid);

  // R5
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> rsp_valid);

  // R5
  rsp_has_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rvalid));

  // R6
  share1_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_share1 == $past(rnd_word));
endmodule

bind mcrypt_if mcrypt_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rvalid(mem_rvalid),
  .rnd_word  (rnd_word),
  .rsp_valid (rsp_valid),
  .rsp_share1(rsp_share1)
);

// File: tb/mcrypt_if_tb.sv
`timescale 1ns/1ps
module mcrypt_if_tb;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic csr_seed_we, csr_sel_we;
  logic [0:0] csr_seed_idx, csr_sel_wdata;
  logic [DW-1:0] csr_seed_wdata;
  logic req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_share0, req_share1, rnd_word;
  logic mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic rsp_valid;
  logic [DW-1:0] rsp_share0, rsp_share1;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem_model [1<<AW];
  logic [DW-1:0] plain [2][1<<AW];

  always #10 clk = ~clk;

  mcrypt_if u_dut (.*);

  // Memory model: write at the edge, read data one cycle after request
  always_ff @(posedge clk) begin
    if (mem_req && mem_we) mem_model[mem_addr] <= mem_wdata;
    mem_rvalid <= mem_req && !mem_we && rst_n;
    mem_rdata  <= mem_model[mem_addr];
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0; csr_seed_we = 0; csr_sel_we = 0;
  endtask

  task automatic set_seed(input int idx, input logic [DW-1:0] v);
    csr_seed_we = 1; csr_seed_idx = 1'(idx); csr_seed_wdata = v;
    @(negedge clk); idle();
  endtask

  task automatic set_sel(input int s);
    csr_sel_we = 1; csr_sel_wdata = 1'(s);
    @(negedge clk); idle();
  endtask

  // Store; returns the word that reached memory
  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] s0, input logic [DW-1:0] s1,
                       output logic [DW-1:0] word);
    req_valid = 1; req_write = 1; req_addr = a; req_share0 = s0; req_share1 = s1;
    #1;
    chk(mem_req && mem_we && mem_addr == a, "R2 store forward", {24'd0, mem_addr}, {24'd0, a});
    @(negedge clk); idle();
    word = mem_model[a];
  endtask

  // Load; returns recombined value. seed_pulse writes seed in the issue cycle.
  task automatic load(input logic [AW-1:0] a, input bit seed_pulse, input logic [DW-1:0] nseed,
                      output logic [DW-1:0] val);
    logic [DW-1:0] r;
    req_valid = 1; req_write = 0; req_addr = a;
    if (seed_pulse) begin csr_seed_we = 1; csr_seed_idx = 1'b0; csr_seed_wdata = nseed; end
    #1;
    chk(mem_req && !mem_we && mem_addr == a, "R2 load forward", {31'd0, mem_we}, 32'd0);
    @(negedge clk); idle();
    r = $urandom; rnd_word = r;
    @(negedge clk);
    chk(rsp_valid, "R5 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_share1 == r, "R6 share1 fresh", rsp_share1, r);
    val = rsp_share0 ^ rsp_share1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] w, w2, v, v2, r, got;
    idle(); csr_seed_idx = 0; csr_sel_wdata = 0; csr_seed_wdata = 0;
    req_addr = 0; req_share0 = 0; req_share1 = 0; rnd_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid, "R1 after reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

    set_seed(0, 32'hA5C3_1F07);
    set_seed(1, 32'h3B79_E2D4);

    // Sweep every address under both keys: R5, R7
    for (int k = 0; k < 2; k++) begin
      set_sel(k);
      for (int a = 0; a < (1 << AW); a++) begin
        v = $urandom; r = $urandom;
        plain[k][a] = v;
        store(AW'(a), v ^ r, r, w);
        chk(w != v, "R7 memory word differs from plain", w, v);
      end
      for (int a = 0; a < (1 << AW); a++) begin
        load(AW'(a), 1'b0, '0, got);
        chk(got == plain[k][a], "R5 recombined", got, plain[k][a]);
      end
    end

    // R3: share split invariance
    set_sel(0);
    v = 32'hDEAD_BEEF;
    store(8'd17, v, 32'd0, w);
    r = 32'h1234_5678;
    store(8'd17, v ^ r, r, w2);
    chk(w == w2, "R3 split invariance", w2, w);

    // R4: keystream constant for fixed seed/address
    v2 = 32'h0F0F_1234;
    store(8'd17, v2, 32'd0, w2);
    chk((w ^ w2) == (v ^ v2), "R4 ciphertext xor", w ^ w2, v ^ v2);

    // R8: key select changes ciphertext
    set_sel(1);
    store(8'd17, v, 32'd0, w2);
    chk(w != w2, "R8 keys differ", w2, w);

    // R9: rewriting seed 1 leaves key 0 data intact
    set_sel(0);
    store(8'd40, v, 32'd0, w);
    set_seed(1, 32'h5555_0001);
    load(8'd40, 1'b0, '0, got);
    chk(got == v, "R9 other seed untouched", got, v);
    set_sel(1);
    store(8'd41, v2, 32'd0, w);
    set_seed(1, 32'h7777_9999);
    load(8'd41, 1'b0, '0, got);
    chk(got != v2, "R9 rewritten seed applies", got, v2);

    // R10: seed write in the issue cycle does not touch the in-flight load
    set_sel(0);
    store(8'd60, v, 32'd0, w);
    load(8'd60, 1'b1, 32'h0BAD_F00D, got);
    chk(got == v, "R10 in-flight load keeps key", got, v);
    load(8'd60, 1'b0, '0, got);
    chk(got != v, "R10 later load uses new seed", got, v);

    @(negedge clk);
    chk(!rsp_valid, "R5 rsp_valid one cycle", {31'd0, rsp_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule